// File: doc/BRIEF.md
# Variable-Speed Correlated-Double-Sampling Pixel Sequencer

This block produces the clock and strobe pattern for one pixel period of a sensor's serial register readout. A single start pulse launches a fixed base timeline of 110 ticks. The timeline drives the three horizontal phase clocks, the reset-gate clock and the summing-well clock. It also drives the reference and signal sample strobes, the track/hold and converter-start strobes, and the clamp and reset strobes of the analog chain. The timeline advances only on cycles where the tick enable is high, so the same block serves any tick rate the system derives from its clock.

The readout speed is chosen by the stretch value, which is latched at start. The timeline freezes twice: once just after the reference sample strobe ends and once just after the signal sample strobe ends. Each freeze lasts as many extra ticks as the stretch value, and during a freeze every output holds its level. Larger stretch values give longer integration and slower, quieter readout. Typical settings are 95, 45, 15 and 5. A dummy-pixel flag, also latched at start, moves the summing-well clock's edges and keeps the conversion strobes quiet, so the pixel is clocked out without being digitised.

Top module: `ccd_pix_seq`

## Requirements
- R1: After reset, and whenever no pixel is in progress, the outputs sit at idle levels: reset_gate_o=0, hclk1_o=1, hclk2_o=0, hclk3_o=0, sumwell_o=0, ref_sample_o=0, sig_sample_o=0, track_hold_o=0, adc_start_o=1, clamp_o=1, sig_reset_o=1, ref_reset_o=1, busy_o=0, done_o=0.
- R2: A start pulse while idle begins a pixel and latches stretch and dummy. The outputs and busy_o show base tick 0 from the second clock edge after start. A start pulse while a pixel is in progress is ignored.
- R3: The timeline moves by one tick position only at a clock edge where tick_en is high. A pixel consumes exactly 110+2*S tick_en pulses, where S is the latched stretch.
- R4: For base tick t (0..109), reset_gate_o is inverted for t in 0..19, hclk1_o for 5..19, hclk2_o for 0..14 and hclk3_o for 10..24. Elsewhere each holds its idle level.
- R5: ref_sample_o is high for t in 50..54 and sig_sample_o is high for t in 85..89.
- R6: In a normal pixel, track_hold_o is high for t in 85..94 and adc_start_o is low for t in 100..104.
- R7: clamp_o is low for t in 25..109. sig_reset_o and ref_reset_o are low for t in 35..109.
- R8: sumwell_o is high for t in 10..54 and 75..109 in a normal pixel, and for t in 10..64 and 75..109 in a dummy pixel.
- R9: Base tick 55 and base tick 95-5=90 are each held for 1+S tick positions. No output changes while either is held.
- R10: In a dummy pixel, track_hold_o stays 0 and adc_start_o stays 1 throughout.
- R11: After the tick that ends base tick 109, busy_o drops and done_o is high for exactly one cycle, with all outputs idle. A pixel with tick_en held high shows busy_o for 110+2*S cycles.
- R12: Changing stretch or dummy during a pixel has no effect on that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start one pixel period (accepted when idle) |
| tick_en | input | 1 | Timeline tick enable |
| stretch | input | 8 | Extra ticks inserted at each freeze point |
| dummy | input | 1 | Dummy pixel: no conversion, alternate summing-well timing |
| reset_gate_o | output | 1 | Output reset-gate clock |
| hclk1_o | output | 1 | Horizontal phase 1 |
| hclk2_o | output | 1 | Horizontal phase 2 |
| hclk3_o | output | 1 | Horizontal phase 3 |
| sumwell_o | output | 1 | Summing-well clock |
| ref_sample_o | output | 1 | Reference-level sample strobe |
| sig_sample_o | output | 1 | Signal-level sample strobe |
| track_hold_o | output | 1 | Track/hold strobe |
| adc_start_o | output | 1 | Converter start, active low |
| clamp_o | output | 1 | Clamp control, active low |
| sig_reset_o | output | 1 | Signal integrator reset, active low |
| ref_reset_o | output | 1 | Reference integrator reset, active low |
| done_o | output | 1 | One-cycle end-of-pixel pulse |
| busy_o | output | 1 | Pixel in progress |

## Verification
The bench drives pixels with stretch values of 95, 45, 15, 5 and 0, with tick_en held high and with tick_en gated to one cycle in three. It compares every output in every cycle against a position model. A sequencer that placed a freeze before the sample strobe ended, rather than after, would stretch the strobe, and the bench would report a mismatch at base ticks 54 and 89. Counting the freeze as S ticks instead of 1+S would shorten the pixel by two. A dummy pixel checks that the converter stays quiet and that the summing-well edge moves. A disturbed pixel changes stretch and dummy and pulses start mid-period, and a design that did not latch them would change length or waveform.

// File: rtl/pix_seq_pkg.sv
// Shared constants for the pixel sequencer: channel indices, idle levels and
// the window (first tick, length) of every single-window output channel.
// Assumes a base timeline of 110 ticks; windows may run past the end and are
// then cut off when the pixel finishes.
package pix_seq_pkg;

    localparam int NCH = 11;

    typedef enum int {
        CH_RGATE = 0,
        CH_H1    = 1,
        CH_H2    = 2,
        CH_H3    = 3,
        CH_REFS  = 4,
        CH_SIGS  = 5,
        CH_TRACK = 6,
        CH_TRIG  = 7,
        CH_CLAMP = 8,
        CH_SRST  = 9,
        CH_RRST  = 10
    } chan_e;

    localparam int unsigned WIN_FIRST [NCH] = '{0, 5, 0, 10, 50, 85, 85, 100, 25, 35, 35};
    localparam int unsigned WIN_LEN   [NCH] = '{20, 15, 15, 15, 5, 5, 10, 5, 85, 75, 75};
    localparam bit          IDLE_LVL  [NCH] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                                1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    // Summing-well clock: two inverted windows, the first one longer in dummy pixels.
    localparam int unsigned SW_A_FIRST     = 10;
    localparam int unsigned SW_A_LEN_NORM  = 45;
    localparam int unsigned SW_A_LEN_DUMMY = 55;
    localparam int unsigned SW_B_FIRST     = 75;
    localparam int unsigned SW_B_LEN       = 50;

    // Freeze points: entered right after each sample strobe ends.
    localparam int unsigned BASE_TICKS = 110;
    localparam int unsigned FREEZE_A   = 55;
    localparam int unsigned FREEZE_B   = 90;

endpackage

// File: rtl/pix_window.sv
// Range detector: hit is high while pos lies in [LO, HI).
// Assumes HI fits in W+1 bits; a zero LO drops the lower compare.
module pix_window #(
    parameter int W  = 7,
    parameter int LO = 0,
    parameter int HI = 1
) (
    input  logic [W-1:0] pos,
    output logic         hit
);
    localparam logic [W:0] LO_V = LO[W:0];
    localparam logic [W:0] HI_V = HI[W:0];

    generate
        if (LO == 0) begin : g_from_zero
            // Window starting at the first tick needs only the upper bound.
            assign hit = ({1'b0, pos} < HI_V);
        end else begin : g_range
            // General window with both bounds.
            assign hit = ({1'b0, pos} >= LO_V) && ({1'b0, pos} < HI_V);
        end
    endgenerate
endmodule

// File: rtl/pix_timebase.sv
// Pixel timebase: accepts start when idle, latches stretch and dummy, and
// walks the base position 0..BASE_LEN-1 on tick enables. At FREEZE_A and
// FREEZE_B the position is held for stretch extra ticks. Ends with a
// one-cycle done pulse. Assumes start is ignored while busy.
module pix_timebase #(
    parameter int BASE_LEN  = 110,
    parameter int STRETCH_W = 8,
    parameter int PT_A      = 55,
    parameter int PT_B      = 90,
    localparam int TW       = $clog2(BASE_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 tick_en,
    input  logic [STRETCH_W-1:0] stretch,
    input  logic                 dummy,
    output logic                 busy,
    output logic                 done,
    output logic [TW-1:0]        pos,
    output logic                 dummy_q
);
    localparam logic [TW-1:0] LAST  = TW'(BASE_LEN - 1);
    localparam logic [TW-1:0] A_PRE = TW'(PT_A - 1);
    localparam logic [TW-1:0] B_PRE = TW'(PT_B - 1);

    logic [STRETCH_W-1:0] stretch_q;
    logic [STRETCH_W-1:0] left;

    // Sequencing state: start, advance, freeze countdown, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            pos       <= '0;
            dummy_q   <= 1'b0;
            stretch_q <= '0;
            left      <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy      <= 1'b1;
                    pos       <= '0;
                    stretch_q <= stretch;
                    dummy_q   <= dummy;
                    left      <= '0;
                end
            end else if (tick_en) begin
                if (left != '0) begin
                    left <= left - 1'b1;
                end else if (pos == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                    if (pos == A_PRE || pos == B_PRE)
                        left <= stretch_q;
                end
            end
        end
    end

    // Position holds without a tick enable.
    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_en) |=> ($stable(pos) && busy));

    // A freeze countdown only runs at one of the two freeze points.
    assert_freeze_place_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (left != '0) |-> (pos == TW'(PT_A) || pos == TW'(PT_B)));

    // The latched stretch does not move while a pixel runs.
    assert_stretch_latched_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(stretch_q));
endmodule

// File: rtl/pix_wave_decode.sv
// Waveform decoder: turns the base position into registered output levels.
// Each single-window channel is its idle level inverted inside its window.
// Conversion strobes are muted in dummy pixels. Idle levels are driven
// when no pixel runs. busy and done pass through the same register stage,
// so every output is aligned and glitch-free.
module pix_wave_decode
    import pix_seq_pkg::*;
#(
    parameter int TW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           busy,
    input  logic           done,
    input  logic [TW-1:0]  pos,
    input  logic           dummy,
    output logic [NCH-1:0] chan_o,
    output logic           sw_o,
    output logic           busy_o,
    output logic           done_o
);
    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_ch
            localparam bit IDL     = IDLE_LVL[i];
            localparam bit IS_CONV = (i == CH_TRACK) || (i == CH_TRIG);
            logic hit;

            pix_window #(.W(TW), .LO(int'(WIN_FIRST[i])),
                         .HI(int'(WIN_FIRST[i] + WIN_LEN[i]))) u_win (
                .pos (pos),
                .hit (hit)
            );

            // Output flop: idle level, inverted inside the window.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chan_o[i] <= IDL;
                else if (busy && hit && !(IS_CONV && dummy))
                    chan_o[i] <= ~IDL;
                else
                    chan_o[i] <= IDL;
            end
        end
    endgenerate

    logic sw_a_norm, sw_a_dummy, sw_b;

    pix_window #(.W(TW), .LO(int'(SW_A_FIRST)),
                 .HI(int'(SW_A_FIRST + SW_A_LEN_NORM))) u_sw_an (
        .pos (pos), .hit (sw_a_norm));
    pix_window #(.W(TW), .LO(int'(SW_A_FIRST)),
                 .HI(int'(SW_A_FIRST + SW_A_LEN_DUMMY))) u_sw_ad (
        .pos (pos), .hit (sw_a_dummy));
    pix_window #(.W(TW), .LO(int'(SW_B_FIRST)),
                 .HI(int'(SW_B_FIRST + SW_B_LEN))) u_sw_b (
        .pos (pos), .hit (sw_b));

    // Summing-well flop and the aligned busy/done stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_o   <= 1'b0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            sw_o   <= busy && ((dummy ? sw_a_dummy : sw_a_norm) || sw_b);
            busy_o <= busy;
            done_o <= done;
        end
    end

    // Dummy pixels never strobe the converter.
    assert_dummy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && dummy) |-> (!chan_o[CH_TRACK] && chan_o[CH_TRIG]));

    // done is a single-cycle pulse.
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // done marks the first idle cycle.
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $fell(busy_o)));
endmodule

// File: rtl/ccd_pix_seq.sv
// Top of the variable-speed correlated-double-sampling pixel sequencer.
// Connects the timebase to the waveform decoder and maps channels to pins.
// Assumes a single clock domain; tick_en sets the timeline rate.
module ccd_pix_seq
    import pix_seq_pkg::*;
#(
    parameter int STRETCH_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 tick_en,
    input  logic [STRETCH_W-1:0] stretch,
    input  logic                 dummy,
    output logic                 reset_gate_o,
    output logic                 hclk1_o,
    output logic                 hclk2_o,
    output logic                 hclk3_o,
    output logic                 sumwell_o,
    output logic                 ref_sample_o,
    output logic                 sig_sample_o,
    output logic                 track_hold_o,
    output logic                 adc_start_o,
    output logic                 clamp_o,
    output logic                 sig_reset_o,
    output logic                 ref_reset_o,
    output logic                 done_o,
    output logic                 busy_o
);
    localparam int TW = $clog2(BASE_TICKS);

    logic          tb_busy, tb_done, tb_dummy;
    logic [TW-1:0] tb_pos;
    logic [NCH-1:0] chan;

    pix_timebase #(
        .BASE_LEN  (int'(BASE_TICKS)),
        .STRETCH_W (STRETCH_W),
        .PT_A      (int'(FREEZE_A)),
        .PT_B      (int'(FREEZE_B))
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick_en (tick_en),
        .stretch (stretch),
        .dummy   (dummy),
        .busy    (tb_busy),
        .done    (tb_done),
        .pos     (tb_pos),
        .dummy_q (tb_dummy)
    );

    pix_wave_decode #(.TW(TW)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (tb_busy),
        .done   (tb_done),
        .pos    (tb_pos),
        .dummy  (tb_dummy),
        .chan_o (chan),
        .sw_o   (sumwell_o),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    assign reset_gate_o = chan[CH_RGATE];
    assign hclk1_o      = chan[CH_H1];
    assign hclk2_o      = chan[CH_H2];
    assign hclk3_o      = chan[CH_H3];
    assign ref_sample_o = chan[CH_REFS];
    assign sig_sample_o = chan[CH_SIGS];
    assign track_hold_o = chan[CH_TRACK];
    assign adc_start_o  = chan[CH_TRIG];
    assign clamp_o      = chan[CH_CLAMP];
    assign sig_reset_o  = chan[CH_SRST];
    assign ref_reset_o  = chan[CH_RRST];
endmodule

// File: tb/sim_ccd_pix_seq.sv
`timescale 1ns/1ps
module sim_ccd_pix_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tick_en = 1'b0;
    logic [7:0] stretch = 8'd0;
    logic dummy = 1'b0;
    logic reset_gate_o, hclk1_o, hclk2_o, hclk3_o, sumwell_o, ref_sample_o;
    logic sig_sample_o, track_hold_o, adc_start_o, clamp_o, sig_reset_o;
    logic ref_reset_o, done_o, busy_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ccd_pix_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tick_en(tick_en),
        .stretch(stretch), .dummy(dummy),
        .reset_gate_o(reset_gate_o), .hclk1_o(hclk1_o), .hclk2_o(hclk2_o),
        .hclk3_o(hclk3_o), .sumwell_o(sumwell_o), .ref_sample_o(ref_sample_o),
        .sig_sample_o(sig_sample_o), .track_hold_o(track_hold_o),
        .adc_start_o(adc_start_o), .clamp_o(clamp_o), .sig_reset_o(sig_reset_o),
        .ref_reset_o(ref_reset_o), .done_o(done_o), .busy_o(busy_o)
    );

    localparam logic [11:0] IDLE_W = 12'b1000_0000_1111 ^ 12'b1100_0000_0000;

    function automatic logic [11:0] out_word();
        return {reset_gate_o, hclk1_o, hclk2_o, hclk3_o, sumwell_o, ref_sample_o,
                sig_sample_o, track_hold_o, adc_start_o, clamp_o, sig_reset_o,
                ref_reset_o};
    endfunction

    // Expected levels for base tick t, from R4..R8 and R10.
    function automatic logic [11:0] exp_word(int t, bit dm);
        logic [11:0] w;
        w[11] = (t < 20);
        w[10] = !(t >= 5 && t < 20);
        w[9]  = (t < 15);
        w[8]  = (t >= 10 && t < 25);
        w[7]  = dm ? ((t >= 10 && t < 65) || t >= 75) : ((t >= 10 && t < 55) || t >= 75);
        w[6]  = (t >= 50 && t < 55);
        w[5]  = (t >= 85 && t < 90);
        w[4]  = !dm && (t >= 85 && t < 95);
        w[3]  = !(!dm && t >= 100 && t < 105);
        w[2]  = !(t >= 25);
        w[1]  = !(t >= 35);
        w[0]  = !(t >= 35);
        return w;
    endfunction

    // Tick position to base tick, with freezes at 55 and 90 (R9).
    function automatic int base_of(int p, int s);
        if (p <= 55) return p;
        if (p <= 55 + s) return 55;
        if (p <= 90 + s) return p - s;
        if (p <= 90 + 2 * s) return 90;
        return p - 2 * s;
    endfunction

    function automatic string req_of(logic [11:0] diff, bit dm, bit frz);
        if (frz) return "R9";
        if (|diff[11:8]) return "R4";
        if (diff[7]) return "R8";
        if (|diff[6:5]) return "R5";
        if (|diff[4:3]) return dm ? "R10" : "R6";
        return "R7";
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset word", int'(out_word()), int'(IDLE_W));
        check("R1", "reset busy", int'(busy_o), 0);
        check("R1", "reset done", int'(done_o), 0);
        rst_n = 1'b1;
    endtask

    // One pixel with per-cycle comparison against a position model.
    task automatic run_pixel(int s, bit dm, int div, bit disturb);
        bit mb = 0, md = 0, ob, od;
        int mp = 0, op, len = 110 + 2 * s, busy_cyc = 0, ticks = 0, trk_hi = 0;
        bit fin = 0;
        for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
            bit tv;
            tv = (cyc % div) == 0;
            tick_en = tv;
            start = (cyc == 0) || (disturb && cyc == 60);
            if (cyc == 0) begin stretch = 8'(s); dummy = dm; end
            if (disturb && cyc == 30) begin stretch = 8'(s + 40); dummy = !dm; end
            @(posedge clk);
            ob = mb; op = mp; od = md;
            md = 0;
            if (!mb) begin
                if (start) begin mb = 1; mp = 0; end
            end else if (tv) begin
                ticks++;
                if (mp == len - 1) begin mb = 0; md = 1; end
                else mp++;
            end
            @(negedge clk);
            begin
                logic [11:0] ew, aw;
                bit frz;
                int t;
                t = base_of(op, s);
                frz = ob && ((op > 55 && op <= 55 + s) || (op > 90 + s && op <= 90 + 2 * s));
                ew = ob ? exp_word(t, dm) : IDLE_W;
                aw = out_word();
                n_chk++;
                if (aw !== ew) begin
                    n_bad++;
                    $display("FAIL %s word pos=%0d actual=%03h expected=%03h",
                             req_of(aw ^ ew, dm, frz), op, aw, ew);
                end
                if (busy_o !== ob) begin
                    n_bad++;
                    $display("FAIL R2 busy pos=%0d actual=%0d expected=%0d", op, busy_o, ob);
                end
                if (done_o !== od) begin
                    n_bad++;
                    $display("FAIL R11 done pos=%0d actual=%0d expected=%0d", op, done_o, od);
                end
                n_chk += 2;
                if (busy_o) busy_cyc++;
                if (track_hold_o) trk_hi++;
                if (od) fin = 1;
            end
        end
        start = 0;
        tick_en = 0;
        check("R11", "pixel finished", int'(fin), 1);
        check("R3", "ticks consumed", ticks, len);
        if (div == 1) check(disturb ? "R12" : "R11", "busy cycles", busy_cyc, len);
        if (dm && !disturb) check("R10", "track cycles", trk_hi, 0);
        @(negedge clk);
        check("R11", "done single", int'(done_o), 0);
        check("R1", "idle word after pixel", int'(out_word()), int'(IDLE_W));
    endtask

    task automatic t_standard(); run_pixel(95, 0, 1, 0); endtask
    task automatic t_quick_dummy(); run_pixel(45, 1, 1, 0); endtask
    task automatic t_turbo_gated(); run_pixel(15, 0, 3, 0); endtask
    task automatic t_fastest(); run_pixel(5, 0, 1, 0); endtask
    task automatic t_no_stretch(); run_pixel(0, 1, 2, 0); endtask
    task automatic t_disturbed(); run_pixel(15, 0, 1, 1); endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        @(negedge clk);
        t_standard();
        t_quick_dummy();
        t_turbo_gated();
        t_fastest();
        t_no_stretch();
        t_disturbed();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule